// File: doc/BRIEF.md
# Raster Timing Generator with Sync-Origin Counters

This block produces display raster timing from a pixel clock. A horizontal and a vertical counter both begin at the leading edge of their sync pulse. Every other boundary is a programmed position measured from that origin: sync end, blank end, blank start, and the width of the border (overscan) band next to each edge of the active picture. From the two counters the block drives sync, blank and data-enable strobes. It also picks what each pixel shows: the incoming pixel, the overscan colour, or the blank colour.

Software programs the timing through a write-only register port. Timing fields go into a staging set, and a commit write moves them to a pending set. The commit first checks the horizontal porches and the horizontal blank length. A timing that fails the check is refused and raises an error flag. A timing that passes is applied at the next frame boundary. While the generator is stopped it is applied at once. Colours, polarities, master enable and the blank-data override act immediately. Live counts and a frame counter are brought out as status ports.

Top module: `raster_timing_gen`

## Requirements
- R1: Each axis counter counts 0 up to its programmed total-minus-one and then wraps to 0. The vertical counter advances only on the horizontal wrap. Status ports show both counts.
- R2: On each axis the raw sync pulse is asserted for counts 0 up to sync width minus 1.
- R3: Control register bit 2 sets horizontal sync polarity and bit 3 sets vertical sync polarity. A value of 0 gives an active-high pin and 1 gives an active-low pin.
- R4: An axis is in blank when its count is below blank end or at or above blank start. hblank_o and vblank_o report this, and vblank_o is the vertical-blank status flag.
- R5: Outside blank, counts below blank end + low border or at or above blank start - high border lie in the border band. pix_sel_o is 2 (blank colour) in either blank, otherwise 1 (overscan colour) in either border band, otherwise 0 (pix_i). de_o is high exactly when pix_sel_o would be 0 with the override clear. Colours pack blue in bits 9:0, green in 19:10 and red in 29:20.
- R6: Control bit 1 (blank-data override) forces pix_sel_o to 2 and outputs the blank colour on every pixel. Clearing it restores normal selection.
- R7: The 24-bit frame counter increments when the vertical counter wraps, and wraps silently.
- R8: Control bit 0 is the master enable. While it is 0 both counters and the frame counter hold their values.
- R9: A commit is refused when total - addressable < 56, when total - blank start < 4, or when blank end - sync width < 4 (horizontal axis). Here addressable = blank start - blank end - both borders. A refused commit sets cfg_err_o and leaves the previous timing in force. An accepted commit clears cfg_err_o.
- R10: Accepted timing takes effect on the edge where the frame wraps. While the master enable is 0 it takes effect on the next edge, so a frame never mixes two timings.
- R11: Write addresses: 0 h total-1, 1 v total-1, 2 h blank (end in 11:0, start in 27:16), 3 v blank (same layout), 4 sync widths (h in 11:0, v in 27:16), 5 control, 6 h borders (left in 11:0, right in 27:16), 7 v borders (top, bottom), 8 blank colour, 9 overscan colour, 10 commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | DATA_W | Register write data |
| pix_i | input | 3*COLOR_W | Incoming pixel |
| hsync_o | output | 1 | Horizontal sync pin, polarity applied |
| vsync_o | output | 1 | Vertical sync pin, polarity applied |
| hblank_o | output | 1 | Horizontal blank |
| vblank_o | output | 1 | Vertical blank / status flag |
| de_o | output | 1 | Data enable (active picture) |
| pix_sel_o | output | 2 | Pixel source: 0 input, 1 overscan, 2 blank |
| pix_o | output | 3*COLOR_W | Selected pixel colour |
| h_count_o | output | CNT_W | Live horizontal count |
| v_count_o | output | CNT_W | Live vertical count |
| frame_cnt_o | output | FRAME_W | Frame counter |
| cfg_err_o | output | 1 | Last commit refused |

## Verification
The hardest case to reach from the ports is a commit that lands on the very edge where the frame wraps. Here the pending timing must wait a whole further frame, and must not be applied halfway. The stimulus follows its own model's counters and times the commit write so that it is sampled on the last pixel of a frame. A second deferral case commits in the middle of a frame and watches the largest horizontal count in the frames before and after the change. A refused commit is followed by a full frame run under the old timing.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
  typedef enum logic [1:0] {
    SEL_ACTIVE = 2'd0,
    SEL_BORDER = 2'd1,
    SEL_BLANK  = 2'd2
  } pix_sel_e;

  typedef enum logic [3:0] {
    A_H_TOTAL   = 4'd0,
    A_V_TOTAL   = 4'd1,
    A_H_BLANK   = 4'd2,
    A_V_BLANK   = 4'd3,
    A_SYNC_W    = 4'd4,
    A_CTRL      = 4'd5,
    A_H_BORDER  = 4'd6,
    A_V_BORDER  = 4'd7,
    A_BLANK_COL = 4'd8,
    A_OVSC_COL  = 4'd9,
    A_COMMIT    = 4'd10
  } reg_addr_e;

  // field index inside one axis record
  localparam int NF     = 6;
  localparam int F_TOT  = 0;
  localparam int F_SYNC = 1;
  localparam int F_BE   = 2;
  localparam int F_BS   = 3;
  localparam int F_BLO  = 4;
  localparam int F_BHI  = 5;

  localparam int AX_H = 0;
  localparam int AX_V = 1;

  localparam int HI_LSB = 16;

  localparam int DEF_H_TOT  = 128;
  localparam int DEF_H_SYNC = 8;
  localparam int DEF_H_BE   = 40;
  localparam int DEF_H_BS   = 120;
  localparam int DEF_H_BLO  = 4;
  localparam int DEF_H_BHI  = 4;
  localparam int DEF_V_TOT  = 10;
  localparam int DEF_V_SYNC = 2;
  localparam int DEF_V_BE   = 3;
  localparam int DEF_V_BS   = 9;
  localparam int DEF_V_BLO  = 1;
  localparam int DEF_V_BHI  = 1;
endpackage

// File: rtl/rtg_axis.sv
module rtg_axis #(
  parameter int CNT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic [CNT_W-1:0] tot_m1_i,
  input  logic [CNT_W-1:0] sync_w_i,
  input  logic [CNT_W-1:0] blank_end_i,
  input  logic [CNT_W-1:0] blank_start_i,
  input  logic [CNT_W-1:0] bord_lo_i,
  input  logic [CNT_W-1:0] bord_hi_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o,
  output logic             sync_o,
  output logic             blank_o,
  output logic             border_o
);
  localparam int EW = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [EW-1:0]    act_lo, cnt_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (step_i) cnt_q <= wrap_o ? '0 : cnt_q + 1'b1;
  end

  // >= keeps the counter bounded if the total shrinks while stopped
  assign wrap_o  = cnt_q >= tot_m1_i;
  assign sync_o  = cnt_q < sync_w_i;
  assign blank_o = (cnt_q < blank_end_i) || (cnt_q >= blank_start_i);

  assign act_lo  = {1'b0, blank_end_i} + {1'b0, bord_lo_i};
  assign cnt_hi  = {1'b0, cnt_q} + {1'b0, bord_hi_i};
  assign border_o = !blank_o &&
                    (({1'b0, cnt_q} < act_lo) || (cnt_hi >= {1'b0, blank_start_i}));

  assign cnt_o = cnt_q;

  // R1
  wrap_to_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && wrap_o) |=> (cnt_q == '0));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/rtg_regs.sv
module rtg_regs
  import rtg_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int COLOR_W    = 10,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int MIN_HBLANK = 56,
  parameter int MIN_PORCH  = 4
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [ADDR_W-1:0]                wr_addr_i,
  input  logic [DATA_W-1:0]                wr_data_i,
  input  logic                             frame_wrap_i,
  output logic [1:0][NF-1:0][CNT_W-1:0]    act_o,
  output logic                             en_o,
  output logic                             blank_data_o,
  output logic                             hpol_o,
  output logic                             vpol_o,
  output logic [3*COLOR_W-1:0]             blank_col_o,
  output logic [3*COLOR_W-1:0]             ovsc_col_o,
  output logic                             err_o
);
  localparam int PW = 3 * COLOR_W;
  localparam int VW = CNT_W + 3;

  typedef logic [1:0][NF-1:0][CNT_W-1:0] cfg_t;

  function automatic cfg_t def_cfg();
    cfg_t c;
    c[AX_H][F_TOT]  = CNT_W'(DEF_H_TOT - 1);
    c[AX_H][F_SYNC] = CNT_W'(DEF_H_SYNC);
    c[AX_H][F_BE]   = CNT_W'(DEF_H_BE);
    c[AX_H][F_BS]   = CNT_W'(DEF_H_BS);
    c[AX_H][F_BLO]  = CNT_W'(DEF_H_BLO);
    c[AX_H][F_BHI]  = CNT_W'(DEF_H_BHI);
    c[AX_V][F_TOT]  = CNT_W'(DEF_V_TOT - 1);
    c[AX_V][F_SYNC] = CNT_W'(DEF_V_SYNC);
    c[AX_V][F_BE]   = CNT_W'(DEF_V_BE);
    c[AX_V][F_BS]   = CNT_W'(DEF_V_BS);
    c[AX_V][F_BLO]  = CNT_W'(DEF_V_BLO);
    c[AX_V][F_BHI]  = CNT_W'(DEF_V_BHI);
    return c;
  endfunction

  cfg_t stg_q, pend_q, act_q;
  logic pend_vld_q, en_q, bde_q, hpol_q, vpol_q, err_q;
  logic [PW-1:0] bcol_q, ocol_q;

  logic [CNT_W-1:0] f_lo, f_hi;
  logic commit, apply, ok;
  logic signed [VW-1:0] s_tot, s_sync, s_be, s_bs, s_blo, s_bhi;
  logic signed [VW-1:0] s_addr, s_hblank, s_fp, s_bp;

  assign f_lo = wr_data_i[CNT_W-1:0];
  assign f_hi = wr_data_i[HI_LSB +: CNT_W];

  assign commit = wr_en_i && (wr_addr_i == ADDR_W'(A_COMMIT));
  assign apply  = pend_vld_q && (!en_q || frame_wrap_i);

  // horizontal legality on the staged set
  always_comb begin
    s_tot    = $signed({3'b000, stg_q[AX_H][F_TOT]}) + VW'(1);
    s_sync   = $signed({3'b000, stg_q[AX_H][F_SYNC]});
    s_be     = $signed({3'b000, stg_q[AX_H][F_BE]});
    s_bs     = $signed({3'b000, stg_q[AX_H][F_BS]});
    s_blo    = $signed({3'b000, stg_q[AX_H][F_BLO]});
    s_bhi    = $signed({3'b000, stg_q[AX_H][F_BHI]});
    s_addr   = s_bs - s_be - s_blo - s_bhi;
    s_hblank = s_tot - s_addr;
    s_fp     = s_tot - s_bs;
    s_bp     = s_be - s_sync;
    ok = (s_hblank >= $signed(VW'(MIN_HBLANK))) &&
         (s_fp >= $signed(VW'(MIN_PORCH))) &&
         (s_bp >= $signed(VW'(MIN_PORCH)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q      <= def_cfg();
      pend_q     <= def_cfg();
      act_q      <= def_cfg();
      pend_vld_q <= 1'b0;
      en_q       <= 1'b0;
      bde_q      <= 1'b0;
      hpol_q     <= 1'b0;
      vpol_q     <= 1'b0;
      bcol_q     <= '0;
      ocol_q     <= '0;
      err_q      <= 1'b0;
    end else begin
      if (apply) begin
        act_q      <= pend_q;
        pend_vld_q <= 1'b0;
      end
      if (commit) begin
        if (ok) begin
          pend_q     <= stg_q;
          pend_vld_q <= 1'b1;
          err_q      <= 1'b0;
        end else begin
          err_q      <= 1'b1;
        end
      end
      if (wr_en_i) begin
        case (wr_addr_i)
          ADDR_W'(A_H_TOTAL):  stg_q[AX_H][F_TOT] <= f_lo;
          ADDR_W'(A_V_TOTAL):  stg_q[AX_V][F_TOT] <= f_lo;
          ADDR_W'(A_H_BLANK): begin
            stg_q[AX_H][F_BE] <= f_lo;
            stg_q[AX_H][F_BS] <= f_hi;
          end
          ADDR_W'(A_V_BLANK): begin
            stg_q[AX_V][F_BE] <= f_lo;
            stg_q[AX_V][F_BS] <= f_hi;
          end
          ADDR_W'(A_SYNC_W): begin
            stg_q[AX_H][F_SYNC] <= f_lo;
            stg_q[AX_V][F_SYNC] <= f_hi;
          end
          ADDR_W'(A_CTRL): begin
            en_q   <= wr_data_i[0];
            bde_q  <= wr_data_i[1];
            hpol_q <= wr_data_i[2];
            vpol_q <= wr_data_i[3];
          end
          ADDR_W'(A_H_BORDER): begin
            stg_q[AX_H][F_BLO] <= f_lo;
            stg_q[AX_H][F_BHI] <= f_hi;
          end
          ADDR_W'(A_V_BORDER): begin
            stg_q[AX_V][F_BLO] <= f_lo;
            stg_q[AX_V][F_BHI] <= f_hi;
          end
          ADDR_W'(A_BLANK_COL): bcol_q <= wr_data_i[PW-1:0];
          ADDR_W'(A_OVSC_COL):  ocol_q <= wr_data_i[PW-1:0];
          default: ;
        endcase
      end
    end
  end

  assign act_o        = act_q;
  assign en_o         = en_q;
  assign blank_data_o = bde_q;
  assign hpol_o       = hpol_q;
  assign vpol_o       = vpol_q;
  assign blank_col_o  = bcol_q;
  assign ovsc_col_o   = ocol_q;
  assign err_o        = err_q;

  // R9
  reject_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !ok) |=> err_o);

  // R9
  reject_keeps_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && !ok && !apply) |=> ($stable(pend_q) && $stable(act_q)));

  // R10
  apply_at_boundary_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(frame_wrap_i || !en_q));
endmodule

// File: rtl/rtg_pix_sel.sv
module rtg_pix_sel
  import rtg_pkg::*;
#(
  parameter int COLOR_W = 10
) (
  input  logic                 blank_data_i,
  input  logic                 hblank_i,
  input  logic                 vblank_i,
  input  logic                 hbord_i,
  input  logic                 vbord_i,
  input  logic [3*COLOR_W-1:0] pix_i,
  input  logic [3*COLOR_W-1:0] blank_col_i,
  input  logic [3*COLOR_W-1:0] ovsc_col_i,
  output logic                 de_o,
  output logic [1:0]           sel_o,
  output logic [3*COLOR_W-1:0] pix_o
);
  pix_sel_e sel;
  logic timing_blank, timing_bord;

  assign timing_blank = hblank_i || vblank_i;
  assign timing_bord  = hbord_i || vbord_i;
  assign de_o         = !timing_blank && !timing_bord;

  always_comb begin
    if (blank_data_i || timing_blank) sel = SEL_BLANK;
    else if (timing_bord)             sel = SEL_BORDER;
    else                              sel = SEL_ACTIVE;
    case (sel)
      SEL_BLANK:  pix_o = blank_col_i;
      SEL_BORDER: pix_o = ovsc_col_i;
      default:    pix_o = pix_i;
    endcase
  end

  assign sel_o = sel;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import rtg_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int COLOR_W    = 10,
  parameter int FRAME_W    = 24,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int MIN_HBLANK = 56,
  parameter int MIN_PORCH  = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [3*COLOR_W-1:0] pix_i,
  output logic                 hsync_o,
  output logic                 vsync_o,
  output logic                 hblank_o,
  output logic                 vblank_o,
  output logic                 de_o,
  output logic [1:0]           pix_sel_o,
  output logic [3*COLOR_W-1:0] pix_o,
  output logic [CNT_W-1:0]     h_count_o,
  output logic [CNT_W-1:0]     v_count_o,
  output logic [FRAME_W-1:0]   frame_cnt_o,
  output logic                 cfg_err_o
);
  localparam int PW = 3 * COLOR_W;

  logic [1:0][NF-1:0][CNT_W-1:0] act;
  logic en, bde, hpol, vpol, frame_wrap;
  logic [PW-1:0] bcol, ocol;
  logic [1:0] step, wrap, sync_raw, blank, bord;
  logic [1:0][CNT_W-1:0] cnt;
  logic [FRAME_W-1:0] frame_q;

  rtg_regs #(
    .CNT_W(CNT_W), .COLOR_W(COLOR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .MIN_HBLANK(MIN_HBLANK), .MIN_PORCH(MIN_PORCH)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .frame_wrap_i(frame_wrap),
    .act_o(act), .en_o(en), .blank_data_o(bde),
    .hpol_o(hpol), .vpol_o(vpol),
    .blank_col_o(bcol), .ovsc_col_o(ocol), .err_o(cfg_err_o)
  );

  assign step[AX_H] = en;
  assign step[AX_V] = en && wrap[AX_H];

  for (genvar a = 0; a < 2; a++) begin : g_axis
    rtg_axis #(.CNT_W(CNT_W)) u_axis (
      .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step[a]),
      .tot_m1_i(act[a][F_TOT]), .sync_w_i(act[a][F_SYNC]),
      .blank_end_i(act[a][F_BE]), .blank_start_i(act[a][F_BS]),
      .bord_lo_i(act[a][F_BLO]), .bord_hi_i(act[a][F_BHI]),
      .cnt_o(cnt[a]), .wrap_o(wrap[a]), .sync_o(sync_raw[a]),
      .blank_o(blank[a]), .border_o(bord[a])
    );
  end

  assign frame_wrap = en && wrap[AX_H] && wrap[AX_V];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         frame_q <= '0;
    else if (frame_wrap) frame_q <= frame_q + 1'b1;
  end

  rtg_pix_sel #(.COLOR_W(COLOR_W)) u_pix (
    .blank_data_i(bde),
    .hblank_i(blank[AX_H]), .vblank_i(blank[AX_V]),
    .hbord_i(bord[AX_H]), .vbord_i(bord[AX_V]),
    .pix_i(pix_i), .blank_col_i(bcol), .ovsc_col_i(ocol),
    .de_o(de_o), .sel_o(pix_sel_o), .pix_o(pix_o)
  );

  assign hsync_o     = sync_raw[AX_H] ^ hpol;
  assign vsync_o     = sync_raw[AX_V] ^ vpol;
  assign hblank_o    = blank[AX_H];
  assign vblank_o    = blank[AX_V];
  assign h_count_o   = cnt[AX_H];
  assign v_count_o   = cnt[AX_V];
  assign frame_cnt_o = frame_q;

  // R7
  frame_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_wrap |=> (frame_cnt_o == $past(frame_cnt_o) + 1'b1));

  // R8
  frame_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> ($stable(frame_cnt_o) && $stable(v_count_o)));

  // R1
  v_step_on_h_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en && wrap[AX_H]) |=> $stable(v_count_o));
endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb;
  import rtg_pkg::*;

  localparam int CW = 12;
  localparam int KW = 10;
  localparam int PW = 3 * KW;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [PW-1:0] pix = '0;

  logic hsync, vsync, hblank, vblank, de, err;
  logic [1:0] sel;
  logic [PW-1:0] pix_out;
  logic [CW-1:0] hcnt, vcnt;
  logic [23:0] frame_cnt;

  raster_timing_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .pix_i(pix),
    .hsync_o(hsync), .vsync_o(vsync), .hblank_o(hblank), .vblank_o(vblank),
    .de_o(de), .pix_sel_o(sel), .pix_o(pix_out),
    .h_count_o(hcnt), .v_count_o(vcnt), .frame_cnt_o(frame_cnt),
    .cfg_err_o(err)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // behavioural reference
  int st[2][6], pd[2][6], ac[2][6];
  bit m_pend, m_en, m_bde, m_hp, m_vp, m_err;
  int m_bcol, m_ocol, m_h, m_v, m_frame;

  task automatic chk(string req, longint act, longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic void set_defaults();
    st[0] = '{DEF_H_TOT-1, DEF_H_SYNC, DEF_H_BE, DEF_H_BS, DEF_H_BLO, DEF_H_BHI};
    st[1] = '{DEF_V_TOT-1, DEF_V_SYNC, DEF_V_BE, DEF_V_BS, DEF_V_BLO, DEF_V_BHI};
    pd = st;
    ac = st;
  endfunction

  always @(posedge clk) begin : model
    bit fw, apply, ok;
    int lo, hi, tot, addrw;
    if (!rst_n) begin
      set_defaults();
      m_pend = 0; m_en = 0; m_bde = 0; m_hp = 0; m_vp = 0; m_err = 0;
      m_bcol = 0; m_ocol = 0; m_h = 0; m_v = 0; m_frame = 0;
    end else begin
      fw = m_en && m_h >= ac[0][0] && m_v >= ac[1][0];
      apply = m_pend && (!m_en || fw);
      if (m_en) begin
        if (m_h >= ac[0][0]) begin
          m_h = 0;
          if (m_v >= ac[1][0]) m_v = 0; else m_v++;
        end else m_h++;
      end
      if (fw) m_frame = (m_frame + 1) % (1 << 24);
      if (apply) begin ac = pd; m_pend = 0; end
      if (wr_en) begin
        lo = int'(wr_data[11:0]);
        hi = int'(wr_data[27:16]);
        case (int'(wr_addr))
          0: st[0][0] = lo;
          1: st[1][0] = lo;
          2: begin st[0][2] = lo; st[0][3] = hi; end
          3: begin st[1][2] = lo; st[1][3] = hi; end
          4: begin st[0][1] = lo; st[1][1] = hi; end
          5: begin m_en = wr_data[0]; m_bde = wr_data[1]; m_hp = wr_data[2]; m_vp = wr_data[3]; end
          6: begin st[0][4] = lo; st[0][5] = hi; end
          7: begin st[1][4] = lo; st[1][5] = hi; end
          8: m_bcol = int'(wr_data[29:0]);
          9: m_ocol = int'(wr_data[29:0]);
          10: begin
            tot = st[0][0] + 1;
            addrw = st[0][3] - st[0][2] - st[0][4] - st[0][5];
            ok = (tot - addrw >= 56) && (tot - st[0][3] >= 4) && (st[0][2] - st[0][1] >= 4);
            if (ok) begin pd = st; m_pend = 1; m_err = 0; end
            else m_err = 1;
          end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin : compare
    bit hb, vb, hd, vd, hs, vs;
    int es, ep;
    if (rst_n && !done) begin
      hs = m_h < ac[0][1];
      vs = m_v < ac[1][1];
      hb = m_h < ac[0][2] || m_h >= ac[0][3];
      vb = m_v < ac[1][2] || m_v >= ac[1][3];
      hd = !hb && (m_h < ac[0][2] + ac[0][4] || m_h >= ac[0][3] - ac[0][5]);
      vd = !vb && (m_v < ac[1][2] + ac[1][4] || m_v >= ac[1][3] - ac[1][5]);
      es = (m_bde || hb || vb) ? 2 : ((hd || vd) ? 1 : 0);
      ep = (es == 2) ? m_bcol : ((es == 1) ? m_ocol : int'(pix));
      chk("R1 h count", hcnt, m_h);
      chk("R1 v count", vcnt, m_v);
      chk("R2/R3 hsync", hsync, hs ^ m_hp);
      chk("R2/R3 vsync", vsync, vs ^ m_vp);
      chk("R4 hblank", hblank, hb);
      chk("R4 vblank", vblank, vb);
      chk("R5 de", de, !hb && !vb && !hd && !vd);
      chk("R5/R6 pix_sel", sel, es);
      chk("R5/R6 pix_o", pix_out, ep);
      chk("R7 frame", frame_cnt, m_frame);
      chk("R9 cfg_err", err, m_err);
    end
  end

  always @(posedge clk) pix <= pix + 30'h0040_1003;

  task automatic wr(input int a, input int d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 32'(d);
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  function automatic int pack2(input int lo, input int hi);
    return (hi << 16) | lo;
  endfunction

  initial begin : stim
    int mx;
    logic [CW-1:0] h0, v0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // reset state, R8: stays put while enable is 0
    @(negedge clk);
    chk("R1 reset h", hcnt, 0);
    chk("R7 reset frame", frame_cnt, 0);
    chk("R9 reset err", err, 0);
    idle(20);
    @(negedge clk);
    chk("R8 idle h", hcnt, 0);

    wr(8, 30'h1234_5678 & 32'h3fff_ffff);   // R11 blank colour
    wr(9, 30'h0abc_def1 & 32'h3fff_ffff);   // R11 overscan colour
    wr(5, 1);
    idle(2 * 128 * 10 + 50);
    @(negedge clk);
    chk("R7 two frames", frame_cnt, 2);

    wr(5, 32'hd);                            // R3 both active low
    idle(400);
    wr(5, 32'hf);                            // R6 override on
    idle(300);
    wr(5, 32'hd);                            // R6 cleared
    idle(200);

    // R8 stop, then resume
    wr(5, 32'hc);
    @(negedge clk);
    h0 = hcnt; v0 = vcnt;
    idle(60);
    @(negedge clk);
    chk("R8 h held", hcnt, h0);
    chk("R8 v held", vcnt, v0);
    wr(5, 32'h1);

    // R9 refused: front porch 2
    wr(2, pack2(40, 126));
    wr(10, 0);
    @(negedge clk);
    chk("R9 err raised", err, 1);
    idle(1400);

    // R10 mid-frame commit of a new timing
    wr(0, 159);
    wr(1, 11);
    wr(2, pack2(50, 150));
    wr(3, pack2(4, 10));
    wr(4, pack2(10, 3));
    wr(6, pack2(6, 6));
    wr(7, pack2(2, 1));
    @(negedge clk);
    while (vcnt != 5) @(negedge clk);
    wr(10, 0);
    @(negedge clk);
    chk("R9 err cleared", err, 0);
    mx = 0;
    while (!(vcnt == 0 && hcnt == 0)) begin
      if (int'(hcnt) > mx) mx = int'(hcnt);
      @(negedge clk);
    end
    chk("R10 old total kept", mx, 127);
    mx = 0;
    @(negedge clk);
    while (!(vcnt == 0 && hcnt == 0)) begin
      if (int'(hcnt) > mx) mx = int'(hcnt);
      @(negedge clk);
    end
    chk("R10 new total", mx, 159);
    idle(500);

    // R10 commit sampled on the frame-wrap edge: applies a frame later
    wr(0, 127);
    wr(1, 9);
    wr(2, pack2(40, 120));
    wr(3, pack2(3, 9));
    wr(4, pack2(8, 2));
    wr(6, pack2(4, 4));
    wr(7, pack2(1, 1));
    forever begin
      @(posedge clk); #1;
      if (m_h == ac[0][0] && m_v == ac[1][0]) break;
    end
    wr_en = 1'b1; wr_addr = 4'(10); wr_data = '0;
    @(posedge clk); #1;
    wr_en = 1'b0;
    idle(160 * 12 + 20);
    @(negedge clk);
    chk("R10 late apply max h", int'(hcnt) <= 127, 1);

    // R10 while stopped the commit applies at once
    wr(5, 32'h0);
    wr(0, 139);
    wr(2, pack2(44, 132));
    wr(10, 0);
    wr(5, 32'h1);
    idle(3 * 140 * 10);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : watchdog
    #(8 * 190000);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule